// File: doc/BRIEF.md
# Letterboxed Monochrome Raster Scanout

This block drives a 640x480 monochrome raster from one pixel clock and shows a 512x342 one-bit image at native size, centred in that raster. All pixels outside the image window are forced to the border colour. The image is read from a video SRAM that a writer also uses. The block reads 16-bit words in the order they are displayed. Each word is fetched a few clocks before it is needed and then shifted out one bit per clock, most significant bit first. A stored 1 is shown as black and a stored 0 as white.

Two framebuffers live in the SRAM. An input selects which one is shown. The block samples that input only at the start of vertical blanking, so one frame always comes entirely from one buffer. While a read is in flight the block raises a busy flag, so the writer can hold off its own access and the read wins. The sizes, porches, window origin, word width and buffer bases are all parameters.

Top module: `mono_scanout`

## Requirements
- R1: Each line is HT = H_VIS+H_FP+H_SYNC+H_BP clocks long. `hsync_n` is low (active low) for exactly H_SYNC clocks. The low pulse starts H_VIS+H_FP clocks after the line's first visible pixel.
- R2: Each frame is VT = V_VIS+V_FP+V_SYNC+V_BP lines. `vsync_n` is low (active low) during lines V_VIS+V_FP through V_VIS+V_FP+V_SYNC-1 of the frame.
- R3: Inside the window, `video` shows the inverted stored bits. The window covers columns IMG_X0..IMG_X0+IMG_W-1 and lines IMG_Y0..IMG_Y0+IMG_H-1. The pixel at window column c comes from bit WORD_W-1-(c mod WORD_W) of word c/WORD_W of that window line. Every other position outputs 0 (the black border).
- R4: The n-th read of a frame (counting from 0) uses address base+n, where base is the frame's buffer base. Each window line therefore takes IMG_W/WORD_W consecutive words.
- R5: Each word is requested exactly once. `mem_rd_req` is high for one clock, three clocks before `video` shows the word's first pixel, and there is no request outside window lines.
- R6: `mem_rdata` is expected to carry the addressed word in the clock after the request. That word is the one shown.
- R7: `rd_busy` is high in the clock of each request and in the clock after it, and low otherwise.
- R8: `fb_sel` (0 selects BASE_A, 1 selects BASE_B) is sampled only when the raster enters the first blanking line (line V_VIS, column 0). That value sets the buffer for the following frame. Changes at any other time have no effect on the addresses used.
- R9: While `rst` is high, `hsync_n` and `vsync_n` are 1, and `video`, `mem_rd_req` and `rd_busy` are 0. After reset the first frame reads from BASE_A. After the first clock with `rst` low, the outputs reflect raster position (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_sel | input | 1 | Framebuffer choice for the next frame |
| mem_rd_req | output | 1 | One-clock SRAM read strobe |
| mem_addr | output | ADDR_W | SRAM word address, valid with the strobe |
| mem_rdata | input | WORD_W | SRAM read data, one clock after the strobe |
| rd_busy | output | 1 | Read in flight; the writer must wait |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| video | output | 1 | Monochrome pixel, 1 = white |

## Verification
The bench uses a reduced raster: a 32x15 total with a 12x5 window of 4-bit words. It compares every output, in every clock, over five frames against a position-based model.

The memory returns a distinct, computed value for each address. A wrong word, a wrong bit order or a missing inversion therefore each produce a different pixel pattern. The buffer select toggles every 160 clocks, both mid-frame and across the sampling point. The bench thereby separates correct start-of-blanking sampling from live sampling or a stale base. Window edges, sync edges and the request and busy timing are checked against the arithmetic schedule, so an off-by-one in any of them shows up.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // true when val lies in [lo, lo+len)
  function automatic logic in_span(input int val, input int lo, input int len);
    return (val >= lo) && (val < lo + len);
  endfunction
endpackage

// File: rtl/scan_timing.sv
module scan_timing #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int HCW    = 10,
  parameter int VCW    = 10
) (
  input  logic           clk,
  input  logic           rst,
  output logic [HCW-1:0] hcnt,
  output logic [VCW-1:0] vcnt,
  output logic           hsync_n,
  output logic           vsync_n
);
  localparam int HT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int VT = V_VIS + V_FP + V_SYNC + V_BP;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt    <= '0;
      vcnt    <= '0;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
    end else begin
      if (int'(hcnt) == HT - 1) begin
        hcnt <= '0;
        if (int'(vcnt) == VT - 1) vcnt <= '0;
        else                      vcnt <= vcnt + VCW'(1);
      end else begin
        hcnt <= hcnt + HCW'(1);
      end
      hsync_n <= !scan_pkg::in_span(int'(hcnt), H_VIS + H_FP, H_SYNC);
      vsync_n <= !scan_pkg::in_span(int'(vcnt), V_VIS + V_FP, V_SYNC);
    end
  end
endmodule

// File: rtl/scan_fetch.sv
module scan_fetch #(
  parameter int V_VIS  = 480,
  parameter int IMG_W  = 512,
  parameter int IMG_H  = 342,
  parameter int IMG_X0 = 64,
  parameter int IMG_Y0 = 69,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 18,
  parameter int BASE_A = 0,
  parameter int BASE_B = 16384,
  parameter int HCW    = 10,
  parameter int VCW    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HCW-1:0]    hcnt,
  input  logic [VCW-1:0]    vcnt,
  input  logic              fb_sel,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic              busy,
  output logic [WORD_W-1:0] word_q
);
  // request issued from counter value three ahead of the word's first column
  localparam int LEAD = IMG_X0 - 3;

  int   col;
  logic go;
  logic cap;
  logic [ADDR_W-1:0] ptr;

  always_comb begin
    col = int'(hcnt) - LEAD;
    go  = scan_pkg::in_span(int'(vcnt), IMG_Y0, IMG_H) &&
          (col >= 0) && (col < IMG_W) && ((col % WORD_W) == 0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= ADDR_W'(BASE_A);
      rd_req  <= 1'b0;
      rd_addr <= '0;
      busy    <= 1'b0;
      cap     <= 1'b0;
      word_q  <= '0;
    end else begin
      rd_req <= go;
      busy   <= go | rd_req;
      cap    <= rd_req;
      if (cap) word_q <= rd_data;
      if (int'(hcnt) == 0 && int'(vcnt) == V_VIS) begin
        ptr <= fb_sel ? ADDR_W'(BASE_B) : ADDR_W'(BASE_A);
      end else if (go) begin
        rd_addr <= ptr;
        ptr     <= ptr + ADDR_W'(1);
      end
    end
  end
endmodule

// File: rtl/scan_shift.sv
module scan_shift #(
  parameter int IMG_W  = 512,
  parameter int IMG_H  = 342,
  parameter int IMG_X0 = 64,
  parameter int IMG_Y0 = 69,
  parameter int WORD_W = 16,
  parameter int HCW    = 10,
  parameter int VCW    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HCW-1:0]    hcnt,
  input  logic [VCW-1:0]    vcnt,
  input  logic [WORD_W-1:0] word_q,
  output logic              video
);
  int   c;
  logic inwin;
  logic first;
  logic [WORD_W-1:0] sh;

  always_comb begin
    c     = int'(hcnt) - IMG_X0;
    inwin = scan_pkg::in_span(int'(vcnt), IMG_Y0, IMG_H) && (c >= 0) && (c < IMG_W);
    first = inwin && ((c % WORD_W) == 0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      video <= 1'b0;
      sh    <= '0;
    end else if (!inwin) begin
      video <= 1'b0;
    end else if (first) begin
      video <= ~word_q[WORD_W-1];
      sh    <= {word_q[WORD_W-2:0], 1'b0};
    end else begin
      video <= ~sh[WORD_W-1];
      sh    <= {sh[WORD_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/mono_scanout.sv
module mono_scanout #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int IMG_W  = 512,
  parameter int IMG_H  = 342,
  parameter int IMG_X0 = 64,
  parameter int IMG_Y0 = 69,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 18,
  parameter int BASE_A = 0,
  parameter int BASE_B = 16384
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fb_sel,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              rd_busy,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              video
);
  localparam int HT  = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int VT  = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HCW = $clog2(HT);
  localparam int VCW = $clog2(VT);

  logic [HCW-1:0]    hcnt;
  logic [VCW-1:0]    vcnt;
  logic [WORD_W-1:0] word_q;

  scan_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .HCW(HCW), .VCW(VCW)
  ) timing_i (
    .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt),
    .hsync_n(hsync_n), .vsync_n(vsync_n)
  );

  scan_fetch #(
    .V_VIS(V_VIS), .IMG_W(IMG_W), .IMG_H(IMG_H), .IMG_X0(IMG_X0), .IMG_Y0(IMG_Y0),
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .BASE_A(BASE_A), .BASE_B(BASE_B),
    .HCW(HCW), .VCW(VCW)
  ) fetch_i (
    .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt), .fb_sel(fb_sel),
    .rd_req(mem_rd_req), .rd_addr(mem_addr), .rd_data(mem_rdata),
    .busy(rd_busy), .word_q(word_q)
  );

  scan_shift #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .IMG_X0(IMG_X0), .IMG_Y0(IMG_Y0),
    .WORD_W(WORD_W), .HCW(HCW), .VCW(VCW)
  ) shift_i (
    .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt),
    .word_q(word_q), .video(video)
  );
endmodule

// File: rtl/mono_scanout_chk.sv
module mono_scanout_chk #(
  parameter int ADDR_W = 18,
  parameter int WORDS  = 10944,
  parameter int BASE_A = 0,
  parameter int BASE_B = 16384
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              rd_busy,
  input logic              hsync_n,
  input logic              vsync_n,
  input logic              video
);
  // R5: a request lasts a single clock
  a_r5_single_clock_req: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |=> !mem_rd_req);
  // R7: busy covers the request clock and the data clock
  a_r7_busy_with_req: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> rd_busy);
  a_r7_busy_after_req: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |=> rd_busy);
  // R3: lit pixels never appear during sync
  a_r3_dark_in_sync: assert property (@(posedge clk) disable iff (rst)
    video |-> (hsync_n && vsync_n));
  // R4: every read lands inside one of the two buffers
  a_r4_addr_in_buffer: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> ((int'(mem_addr) >= BASE_A && int'(mem_addr) < BASE_A + WORDS) ||
                    (int'(mem_addr) >= BASE_B && int'(mem_addr) < BASE_B + WORDS)));
  // R2: vertical sync spans whole lines, never a single clock
  a_r2_vsync_not_glitch: assert property (@(posedge clk) disable iff (rst)
    $fell(vsync_n) |=> !vsync_n);
endmodule

bind mono_scanout mono_scanout_chk #(
  .ADDR_W(ADDR_W), .WORDS((IMG_W / WORD_W) * IMG_H), .BASE_A(BASE_A), .BASE_B(BASE_B)
) chk_i (
  .clk(clk), .rst(rst), .mem_rd_req(mem_rd_req), .mem_addr(mem_addr),
  .rd_busy(rd_busy), .hsync_n(hsync_n), .vsync_n(vsync_n), .video(video)
);

// File: tb/mono_scanout_tb_top.sv
`timescale 1ns/1ps
module mono_scanout_tb_top;
  localparam int H_VIS = 24, H_FP = 2, H_SYNC = 3, H_BP = 3;
  localparam int V_VIS = 10, V_FP = 1, V_SYNC = 2, V_BP = 2;
  localparam int IMG_W = 12, IMG_H = 5, IMG_X0 = 4, IMG_Y0 = 2;
  localparam int WORD_W = 4, ADDR_W = 8, BASE_A = 16, BASE_B = 96;
  localparam int HT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int VT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int FT = HT * VT;
  localparam int WPL = IMG_W / WORD_W;
  localparam int RUN = 5 * FT + 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fb_sel = 1'b0;
  logic mem_rd_req, rd_busy, hsync_n, vsync_n, video;
  logic [ADDR_W-1:0] mem_addr;
  logic [WORD_W-1:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mono_scanout #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .IMG_W(IMG_W), .IMG_H(IMG_H), .IMG_X0(IMG_X0), .IMG_Y0(IMG_Y0),
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .BASE_A(BASE_A), .BASE_B(BASE_B)
  ) dut_i (
    .clk(clk), .rst(rst), .fb_sel(fb_sel), .mem_rd_req(mem_rd_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .rd_busy(rd_busy),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .video(video)
  );

  function automatic logic [WORD_W-1:0] memf(input int a);
    int t;
    t = (a * 5 + 9) ^ (a >> 2);
    return t[WORD_W-1:0];
  endfunction

  // SRAM model: one clock of read latency (R6)
  always_ff @(posedge clk) begin
    if (mem_rd_req) mem_rdata <= memf(int'(mem_addr));
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  initial begin : watchdog
    repeat (RUN + 1000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int frame_base;
    int exp_ptr;
    frame_base = BASE_A;
    exp_ptr    = BASE_A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk(hsync_n == 1'b1, "R9 hsync_n in reset", int'(hsync_n), 1);
    chk(vsync_n == 1'b1, "R9 vsync_n in reset", int'(vsync_n), 1);
    chk(video == 1'b0, "R9 video in reset", int'(video), 0);
    chk(mem_rd_req == 1'b0, "R9 req in reset", int'(mem_rd_req), 0);
    chk(rd_busy == 1'b0, "R9 busy in reset", int'(rd_busy), 0);
    rst = 1'b0;
    for (int k = 1; k <= RUN; k++) begin
      int p, h, v, hk, vk, c2, c, r, w, b;
      bit req_exp, req_prev, win;
      logic [WORD_W-1:0] wd;
      @(posedge clk);
      // R8: select sampled when the pre-edge position is (col 0, line V_VIS)
      if (((k - 1) % FT) == V_VIS * HT) begin
        frame_base = fb_sel ? BASE_B : BASE_A;
        exp_ptr    = frame_base;
      end
      @(negedge clk);
      p = k - 1;
      h = p % HT;
      v = (p / HT) % VT;
      chk(hsync_n == !(h >= H_VIS + H_FP && h < H_VIS + H_FP + H_SYNC),
          "R1 hsync_n", int'(hsync_n), int'(!(h >= H_VIS + H_FP && h < H_VIS + H_FP + H_SYNC)));
      chk(vsync_n == !(v >= V_VIS + V_FP && v < V_VIS + V_FP + V_SYNC),
          "R2 vsync_n", int'(vsync_n), int'(!(v >= V_VIS + V_FP && v < V_VIS + V_FP + V_SYNC)));
      win = (h >= IMG_X0) && (h < IMG_X0 + IMG_W) && (v >= IMG_Y0) && (v < IMG_Y0 + IMG_H);
      if (win) begin
        c = h - IMG_X0;
        r = v - IMG_Y0;
        w = c / WORD_W;
        b = WORD_W - 1 - (c % WORD_W);
        wd = memf(frame_base + r * WPL + w);
        chk(video == !wd[b], "R3 R6 window pixel", int'(video), int'(!wd[b]));
      end else begin
        chk(video == 1'b0, "R3 border pixel", int'(video), 0);
      end
      // R5: request schedule; R4: sequential addresses
      hk = k % HT;
      vk = (k / HT) % VT;
      c2 = hk - (IMG_X0 - 2);
      req_exp = (vk >= IMG_Y0) && (vk < IMG_Y0 + IMG_H) && (c2 >= 0) && (c2 < IMG_W) &&
                ((c2 % WORD_W) == 0);
      hk = (k - 1) % HT;
      vk = ((k - 1) / HT) % VT;
      c2 = hk - (IMG_X0 - 2);
      req_prev = (k > 1) && (vk >= IMG_Y0) && (vk < IMG_Y0 + IMG_H) && (c2 >= 0) &&
                 (c2 < IMG_W) && ((c2 % WORD_W) == 0);
      chk(mem_rd_req == req_exp, "R5 request timing", int'(mem_rd_req), int'(req_exp));
      if (req_exp) begin
        chk(int'(mem_addr) == exp_ptr, "R4 R8 read address", int'(mem_addr), exp_ptr);
        exp_ptr++;
      end
      chk(rd_busy == (req_exp || req_prev), "R7 busy flag", int'(rd_busy),
          int'(req_exp || req_prev));
      // select toggles every 160 clocks, also mid-frame
      fb_sel = ((k / 160) % 2) == 1;
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule